// File: doc/BRIEF.md
# Multi-Cycle Multiply-Accumulate Unit with Accumulator Commands

This unit holds a 48-bit two's-complement accumulator. A host drives it through a small command port: an opcode, two 24-bit operands and a 48-bit data word, all qualified by a valid strobe. A command is taken when `cmd_valid` is high and the unit is idle.

Each command takes its own fixed number of clocks. The multiply command forms the full signed 24×24 product and adds it into the accumulator. Two load commands write the accumulator: one takes a 32-bit word and one takes all 48 bits. Two store commands copy the accumulator onto the result port: one returns the top 32 bits and one returns all 48 bits. A clear command zeroes the accumulator.

The unit raises `busy` for the whole duration of a command and marks its last cycle with a one-cycle `done` pulse. Opcodes outside the defined set complete in a single clock and raise an error flag.

Top module: `mac_cmd_unit`

## Requirements
- R1: After reset, `busy`, `done` and `err` are low, `result` is zero and the accumulator is zero.
- R2: Opcode 1 (MAC) adds the signed 48-bit product `cmd_a × cmd_b` into the accumulator. The addition wraps modulo 2^48 and does not saturate.
- R3: Opcode 0 (CLEAR) sets the accumulator to zero. The command lasts 4 clocks.
- R4: Opcode 2 (LOAD32) writes `{cmd_data[31:0], 16'h0000}` into the accumulator. Opcode 3 (LOAD48) writes `cmd_data[47:0]`. Each load lasts 9 clocks.
- R5: Opcode 4 (STORE32) drives `result` with the accumulator's bits 47:16, zero-extended to 48 bits, in 7 clocks. Opcode 5 (STORE48) drives `result` with the whole accumulator in 11 clocks. Neither store changes the accumulator.
- R6: The MAC command lasts 8 clocks.
- R7: A command is accepted at a clock edge where `cmd_valid` is high and `busy` is low. For a command that lasts L clocks, `busy` is high for exactly the L cycles that follow acceptance. `done` is high only in the last of those cycles. `result` changes only in a cycle where `done` is high, and it holds its value otherwise.
- R8: While `busy` is high, a command presented on the port is ignored. It changes neither the accumulator nor the running command's latency.
- R9: Opcodes 6 and 7 are illegal. They last 1 clock, leave the accumulator unchanged and set `err`. `err` changes only when a command is accepted, and the next legal command clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command opcode |
| cmd_a | input | 24 | First signed multiplier operand |
| cmd_b | input | 24 | Second signed multiplier operand |
| cmd_data | input | 48 | Load data word |
| busy | output | 1 | Command in progress |
| done | output | 1 | Last cycle of a command |
| err | output | 1 | Last accepted command was illegal |
| result | output | 48 | Store result |

## Verification
The bench builds the unit with its default widths (24-bit operands, 48-bit accumulator, 32-bit narrow word) and default latencies (4, 7, 8, 9 and 11 clocks). With these values, products of the extreme operands 0x7FFFFF and 0x800000 drive the sum past 2^48, so the wrap rule is exercised. A 48-bit load with non-zero low bits, followed by a 32-bit load, shows that the narrow load clears the low 16 bits. Every latency can be measured cycle by cycle, including the single-clock illegal case and a command pushed in while the unit is busy.

// File: rtl/mac_cmd_unit.sv
module mac_cmd_unit #(
  parameter int OPW       = 24,
  parameter int ACCW      = 48,
  parameter int WORDW     = 32,
  parameter int LAT_CLR   = 4,
  parameter int LAT_MAC   = 8,
  parameter int LAT_LOAD  = 9,
  parameter int LAT_ST_N  = 7,
  parameter int LAT_ST_W  = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [OPW-1:0]  cmd_a,
  input  logic [OPW-1:0]  cmd_b,
  input  logic [ACCW-1:0] cmd_data,
  output logic            busy,
  output logic            done,
  output logic            err,
  output logic [ACCW-1:0] result
);
  localparam int PRODW = 2 * OPW;
  localparam int LOWW  = ACCW - WORDW;
  localparam int LMAX  = (LAT_ST_W > LAT_LOAD) ? LAT_ST_W : LAT_LOAD;
  localparam int CNTW  = $clog2(LMAX + 1);

  localparam logic [2:0] OP_CLR = 3'd0, OP_MAC = 3'd1, OP_LDN = 3'd2,
                         OP_LDW = 3'd3, OP_STN = 3'd4, OP_STW = 3'd5;

  function automatic logic [CNTW-1:0] lat_of(input logic [2:0] op);
    case (op)
      OP_CLR:         lat_of = CNTW'(LAT_CLR);
      OP_MAC:         lat_of = CNTW'(LAT_MAC);
      OP_LDN, OP_LDW: lat_of = CNTW'(LAT_LOAD);
      OP_STN:         lat_of = CNTW'(LAT_ST_N);
      OP_STW:         lat_of = CNTW'(LAT_ST_W);
      default:        lat_of = CNTW'(1);
    endcase
  endfunction

  logic [2:0]             op_q;
  logic signed [OPW-1:0]  a_q, b_q;
  logic [ACCW-1:0]        data_q, acc_q;
  logic [CNTW-1:0]        cnt_q;
  logic signed [PRODW-1:0] prod;
  logic signed [ACCW-1:0]  prod_ext;
  logic                   accept, legal;

  assign accept   = cmd_valid && !busy;
  assign legal    = cmd_op <= OP_STW;
  assign prod     = a_q * b_q;
  assign prod_ext = ACCW'(prod);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      result <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      op_q   <= OP_CLR;
      a_q    <= '0;
      b_q    <= '0;
      data_q <= '0;
    end else if (accept) begin
      op_q   <= cmd_op;
      a_q    <= cmd_a;
      b_q    <= cmd_b;
      data_q <= cmd_data;
      busy   <= 1'b1;
      err    <= !legal;
      cnt_q  <= lat_of(cmd_op) - CNTW'(1);
      done   <= !legal;
    end else if (busy) begin
      if (done) begin
        busy <= 1'b0;
        done <= 1'b0;
      end else begin
        cnt_q <= cnt_q - CNTW'(1);
        if (cnt_q == CNTW'(1)) begin
          done <= 1'b1;
          case (op_q)
            OP_CLR:  acc_q  <= '0;
            OP_MAC:  acc_q  <= acc_q + prod_ext;
            OP_LDN:  acc_q  <= {data_q[WORDW-1:0], {LOWW{1'b0}}};
            OP_LDW:  acc_q  <= data_q;
            OP_STN:  result <= {{LOWW{1'b0}}, acc_q[ACCW-1 -: WORDW]};
            OP_STW:  result <= acc_q;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

module mac_cmd_unit_chk #(
  parameter int LAT_CLR  = 4,
  parameter int LAT_MAC  = 8,
  parameter int LAT_LOAD = 9,
  parameter int LAT_ST_N = 7,
  parameter int LAT_ST_W = 11
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [2:0]  cmd_op,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [47:0] result
);
  int bcnt, exp_lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt    <= 0;
      exp_lat <= 0;
    end else if (cmd_valid && !busy) begin
      bcnt <= 1;
      case (cmd_op)
        3'd0:       exp_lat <= LAT_CLR;
        3'd1:       exp_lat <= LAT_MAC;
        3'd2, 3'd3: exp_lat <= LAT_LOAD;
        3'd4:       exp_lat <= LAT_ST_N;
        3'd5:       exp_lat <= LAT_ST_W;
        default:    exp_lat <= 1;
      endcase
    end else if (busy && !done) begin
      bcnt <= bcnt + 1;
    end
  end

  a_r7_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // Covers R3, R4, R5 and R6, and R8 (a refused command does not restart the count)
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bcnt == exp_lat));
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);
  a_r9_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op > 3'd5) |=> (done && err));
  a_r9_err_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err) |-> $past(cmd_valid && !busy));
endmodule

bind mac_cmd_unit mac_cmd_unit_chk #(
  .LAT_CLR(LAT_CLR), .LAT_MAC(LAT_MAC), .LAT_LOAD(LAT_LOAD),
  .LAT_ST_N(LAT_ST_N), .LAT_ST_W(LAT_ST_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .busy(busy), .done(done), .err(err), .result(result)
);

// File: tb/mac_cmd_unit_test.sv
module mac_cmd_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [23:0] cmd_a = '0, cmd_b = '0;
  logic [47:0] cmd_data = '0;
  logic        busy, done, err;
  logic [47:0] result;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mac_cmd_unit uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_a(cmd_a), .cmd_b(cmd_b), .cmd_data(cmd_data),
    .busy(busy), .done(done), .err(err), .result(result)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [23:0] a;
    logic [23:0] b;
    logic [47:0] d;
    logic        chk;
    logic [47:0] exp;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{3'd5, 24'h0,      24'h0,      48'h0,            1'b1, 48'h0,            4'd11},
    '{3'd0, 24'h0,      24'h0,      48'h0,            1'b0, 48'h0,            4'd4},
    '{3'd1, 24'd3,      24'd5,      48'h0,            1'b0, 48'h0,            4'd8},
    '{3'd1, 24'hFFFFFE, 24'd7,      48'h0,            1'b0, 48'h0,            4'd8},
    '{3'd5, 24'h0,      24'h0,      48'h0,            1'b1, 48'h1,            4'd11},
    '{3'd3, 24'h0,      24'h0,      48'h123456789ABC, 1'b0, 48'h0,            4'd9},
    '{3'd4, 24'h0,      24'h0,      48'h0,            1'b1, 48'h000012345678, 4'd7},
    '{3'd2, 24'h0,      24'h0,      48'hFFFFDEADBEEF, 1'b0, 48'h0,            4'd9},
    '{3'd5, 24'h0,      24'h0,      48'h0,            1'b1, 48'hDEADBEEF0000, 4'd11},
    '{3'd1, 24'h7FFFFF, 24'h7FFFFF, 48'h0,            1'b0, 48'h0,            4'd8},
    '{3'd5, 24'h0,      24'h0,      48'h0,            1'b1, 48'h1EADBDEF0001, 4'd11},
    '{3'd1, 24'h800000, 24'h800000, 48'h0,            1'b0, 48'h0,            4'd8},
    '{3'd1, 24'h800000, 24'h7FFFFF, 48'h0,            1'b0, 48'h0,            4'd8},
    '{3'd5, 24'h0,      24'h0,      48'h0,            1'b1, 48'h1EADBE6F0001, 4'd11},
    '{3'd4, 24'h0,      24'h0,      48'h0,            1'b1, 48'h00001EADBE6F, 4'd7},
    '{3'd3, 24'h0,      24'h0,      48'hABCDEF012345, 1'b0, 48'h0,            4'd9},
    '{3'd6, 24'd9,      24'd9,      48'h0,            1'b0, 48'h0,            4'd1},
    '{3'd7, 24'd9,      24'd9,      48'h111111111111, 1'b0, 48'h0,            4'd1},
    '{3'd5, 24'h0,      24'h0,      48'h0,            1'b1, 48'hABCDEF012345, 4'd11},
    '{3'd0, 24'h0,      24'h0,      48'h0,            1'b0, 48'h0,            4'd4},
    '{3'd5, 24'h0,      24'h0,      48'h0,            1'b1, 48'h0,            4'd11}
  };

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0:       return "R3";
      3'd1:       return "R2/R6";
      3'd2, 3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      default:    return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [23:0] a, input logic [23:0] b,
                         input logic [47:0] d, input bit poke,
                         output int lat, output logic [47:0] res, output logic e);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 0;
    res = result;
    e = err;
    for (int i = 0; i < 20; i++) begin
      if (busy) lat++;
      if (done) begin
        res = result;
        e = err;
        break;
      end
      if (poke && i == 1) begin
        cmd_valid = 1'b1; cmd_op = 3'd3; cmd_data = 48'h0BADBADBAD00;
      end else begin
        cmd_valid = 1'b0;
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [47:0] res;
    logic e;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", 48'(busy), 48'h0);
    check("R1 done", 48'(done), 48'h0);
    check("R1 err", 48'(err), 48'h0);
    check("R1 result", result, 48'h0);

    for (int v = 0; v < NV; v++) begin
      run_cmd(VEC[v].op, VEC[v].a, VEC[v].b, VEC[v].d, 1'b0, lat, res, e);
      check({tag_of(VEC[v].op), " R7 latency"}, 48'(lat), 48'(VEC[v].lat));
      check({tag_of(VEC[v].op), " err"}, 48'(e), 48'(VEC[v].op > 3'd5));
      if (VEC[v].chk)
        check({v == 0 ? "R1 " : "", tag_of(VEC[v].op), " result"}, res, VEC[v].exp);
    end

    // R8: a load pushed in while busy is ignored
    run_cmd(3'd3, 24'h0, 24'h0, 48'h00C0FFEE1234, 1'b1, lat, res, e);
    check("R8 latency unchanged", 48'(lat), 48'd9);
    @(negedge clk);
    check("R7 busy released", 48'(busy), 48'h0);
    run_cmd(3'd5, 24'h0, 24'h0, 48'h0, 1'b0, lat, res, e);
    check("R8 accumulator kept", res, 48'h00C0FFEE1234);

    // R9: err is set by an illegal opcode, held, and cleared by a legal one
    run_cmd(3'd6, 24'h0, 24'h0, 48'h0, 1'b0, lat, res, e);
    check("R9 err set", 48'(e), 48'h1);
    repeat (3) @(negedge clk);
    check("R9 err held while idle", 48'(err), 48'h1);
    check("R7 result held", result, 48'h00C0FFEE1234);
    run_cmd(3'd0, 24'h0, 24'h0, 48'h0, 1'b0, lat, res, e);
    check("R9 err cleared", 48'(e), 48'h0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule